// File: doc/BRIEF.md
# Conversion Request Pending Flags

This block keeps track of start-of-conversion requests for a sampling converter sequencer. It holds sixteen request slots. Each slot owns a 2-bit chaining select that decides where its trigger comes from: the slot's own pre-selected trigger input, interrupt line 1, or interrupt line 2. When the selected source fires, or when software writes a 1 to the slot's bit in the force register, the slot's pending flag is set. The sequencer clears a flag by signalling that the slot's conversion has started.

A request that arrives while the flag is still set and is not being consumed in the same cycle is lost. The block records this in a per-slot overflow bit, which a dedicated clear input removes. When a request and a conversion start meet on the same cycle, the request wins and the overflow bit is left as it was. Software reaches the select fields, the force register and both status vectors through a small word-wide register port. Writes are synchronous and reads are combinational.

Top module: `conv_req_flags`

## Requirements
- R1: After reset, all select fields, pending flags and overflow bits are 0, and every register reads as 0.
- R2: Select register at address 0 holds the fields of slots 0 to 7, and address 1 holds slots 8 to 15. Slot k uses bits 2(k mod 8)+1 : 2(k mod 8), so slot 15 is in bits 15:14 of address 1. A write is read back unchanged.
- R3: With select 00, the slot's bit of norm_trig_i sets its pending flag at the next clock edge, and both interrupt lines have no effect on that slot.
- R4: With select 01, irq1_i sets the pending flag. With select 10, irq2_i sets it. In both cases the slot's norm_trig_i bit and the other interrupt line have no effect.
- R5: With select 11, neither the interrupt lines nor norm_trig_i set the flag.
- R6: A write to address 2 sets the pending flag of every slot whose data bit is 1, at that clock edge. It leaves slots with a 0 bit unchanged. Address 2 always reads 0.
- R7: A conv_start_i bit clears that slot's pending flag at the next edge when no set request is present.
- R8: When a set request and conv_start_i reach a slot in the same cycle, the flag ends up 1 and the overflow bit keeps its value.
- R9: A set request reaching a slot whose flag is already 1, with no conv_start_i for that slot, sets its overflow bit.
- R10: An ovf_clr_i bit clears that slot's overflow bit at the next edge. An overflow event in the same cycle takes priority and leaves the bit at 1.
- R11: Address 3 reads the pending vector, address 4 reads the overflow vector, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| norm_trig_i | input | 16 | Per-slot pre-selected normal trigger pulses |
| irq1_i | input | 1 | Converter interrupt line 1 |
| irq2_i | input | 1 | Converter interrupt line 2 |
| conv_start_i | input | 16 | Per-slot conversion-started pulses from the sequencer |
| ovf_clr_i | input | 16 | Per-slot overflow clear |
| pend_o | output | 16 | Pending flag vector |
| ovf_o | output | 16 | Overflow status vector |

## Verification
The bench builds the block with its default parameters: sixteen slots and a 16-bit data path. That yields exactly two select registers, so the field packing of slots 8 to 15, and slot 15 in the top bits of the upper register, can be observed directly. With these values the force, pending and overflow registers span the full word, so every bit position of the set-versus-clear collision and of the overflow clear can be driven. A long mixed run with random triggers, starts, clears and select rewrites reaches coincidences that the directed phases do not.

// File: rtl/conv_req_pkg.sv
package conv_req_pkg;

  typedef enum logic [1:0] {
    TSEL_NORMAL = 2'b00,
    TSEL_IRQ1   = 2'b01,
    TSEL_IRQ2   = 2'b10,
    TSEL_BAD    = 2'b11
  } tsel_e;

  // Pick the trigger source for one slot; the invalid code selects nothing.
  function automatic logic pick_trigger(input logic [1:0] sel, input logic norm,
                                        input logic irq1, input logic irq2);
    logic hit;
    unique case (tsel_e'(sel))
      TSEL_NORMAL: hit = norm;
      TSEL_IRQ1:   hit = irq1;
      TSEL_IRQ2:   hit = irq2;
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Set has priority over the conversion-start clear.
  function automatic logic pend_next(input logic pend, input logic set, input logic clr);
    return set | (pend & ~clr);
  endfunction

  // A request is lost when the flag is held and not consumed this cycle.
  function automatic logic lost_request(input logic pend, input logic set, input logic clr);
    return set & pend & ~clr;
  endfunction

  function automatic logic ovf_next(input logic ovf, input logic lost, input logic ovf_clr);
    logic nxt;
    if (lost)         nxt = 1'b1;
    else if (ovf_clr) nxt = 1'b0;
    else              nxt = ovf;
    return nxt;
  endfunction

endpackage

// File: rtl/conv_req_regs.sv
module conv_req_regs #(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_wr_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  input  logic [NUM_SLOTS-1:0]   pend_i,
  input  logic [NUM_SLOTS-1:0]   ovf_i,
  output logic [2*NUM_SLOTS-1:0] sel_flat_o,
  output logic [NUM_SLOTS-1:0]   force_o,
  output logic [DATA_W-1:0]      reg_rdata_o
);
  localparam int FIELDS_PER_REG = DATA_W / 2;
  localparam int SEL_REGS       = (NUM_SLOTS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
  localparam int FORCE_ADDR     = SEL_REGS;
  localparam int PEND_ADDR      = SEL_REGS + 1;
  localparam int OVF_ADDR       = SEL_REGS + 2;

  logic [DATA_W-1:0]          sel_q [SEL_REGS];
  logic [SEL_REGS*DATA_W-1:0] sel_all;

  generate
    for (genvar r = 0; r < SEL_REGS; r++) begin : g_selreg
      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          sel_q[r] <= '0;
        end else if (reg_wr_i && (reg_addr_i == ADDR_W'(r))) begin
          sel_q[r] <= reg_wdata_i;
        end
      end
      assign sel_all[r*DATA_W +: DATA_W] = sel_q[r];
    end
  endgenerate

  assign sel_flat_o = sel_all[2*NUM_SLOTS-1:0];

  // Force bits are pulses on the write cycle only; nothing is stored.
  assign force_o = (reg_wr_i && (reg_addr_i == ADDR_W'(FORCE_ADDR)))
                   ? reg_wdata_i[NUM_SLOTS-1:0] : '0;

  always_comb begin
    reg_rdata_o = '0;
    for (int r = 0; r < SEL_REGS; r++) begin
      if (reg_addr_i == ADDR_W'(r)) reg_rdata_o = sel_q[r];
    end
    if (reg_addr_i == ADDR_W'(PEND_ADDR)) reg_rdata_o[NUM_SLOTS-1:0] = pend_i;
    if (reg_addr_i == ADDR_W'(OVF_ADDR))  reg_rdata_o[NUM_SLOTS-1:0] = ovf_i;
  end

endmodule

// File: rtl/conv_req_trig.sv
module conv_req_trig
  import conv_req_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic [2*NUM_SLOTS-1:0] sel_flat_i,
  input  logic [NUM_SLOTS-1:0]   norm_trig_i,
  input  logic                   irq1_i,
  input  logic                   irq2_i,
  input  logic [NUM_SLOTS-1:0]   force_i,
  output logic [NUM_SLOTS-1:0]   set_o
);
  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      logic hw_hit;
      assign hw_hit   = pick_trigger(sel_flat_i[2*k +: 2], norm_trig_i[k], irq1_i, irq2_i);
      assign set_o[k] = hw_hit | force_i[k];
    end
  endgenerate
endmodule

// File: rtl/conv_req_slot.sv
module conv_req_slot
  import conv_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ovf_clr_i,
  output logic pend_o,
  output logic ovf_o
);
  logic lost;
  assign lost = lost_request(pend_o, set_i, clr_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      pend_o <= pend_next(pend_o, set_i, clr_i);
      ovf_o  <= ovf_next(ovf_o, lost, ovf_clr_i);
    end
  end
endmodule

// File: rtl/conv_req_flags.sv
module conv_req_flags #(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [NUM_SLOTS-1:0] norm_trig_i,
  input  logic                 irq1_i,
  input  logic                 irq2_i,
  input  logic [NUM_SLOTS-1:0] conv_start_i,
  input  logic [NUM_SLOTS-1:0] ovf_clr_i,
  output logic [NUM_SLOTS-1:0] pend_o,
  output logic [NUM_SLOTS-1:0] ovf_o
);
  // Internal events, named for the checker.
  logic [2*NUM_SLOTS-1:0] sel_flat;
  logic [NUM_SLOTS-1:0]   force_vec;
  logic [NUM_SLOTS-1:0]   set_vec;
  logic [NUM_SLOTS-1:0]   clr_vec;

  assign clr_vec = conv_start_i;

  conv_req_regs #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .pend_i      (pend_o),
    .ovf_i       (ovf_o),
    .sel_flat_o  (sel_flat),
    .force_o     (force_vec),
    .reg_rdata_o (reg_rdata_o)
  );

  conv_req_trig #(.NUM_SLOTS(NUM_SLOTS)) u_trig (
    .sel_flat_i  (sel_flat),
    .norm_trig_i (norm_trig_i),
    .irq1_i      (irq1_i),
    .irq2_i      (irq2_i),
    .force_i     (force_vec),
    .set_o       (set_vec)
  );

  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      conv_req_slot u_slot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set_vec[k]),
        .clr_i     (clr_vec[k]),
        .ovf_clr_i (ovf_clr_i[k]),
        .pend_o    (pend_o[k]),
        .ovf_o     (ovf_o[k])
      );
    end
  endgenerate

endmodule

// File: rtl/conv_req_flags_chk.sv
module conv_req_flags_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   reg_wr_i,
  input logic [ADDR_W-1:0]      reg_addr_i,
  input logic [DATA_W-1:0]      reg_wdata_i,
  input logic [DATA_W-1:0]      reg_rdata_o,
  input logic [2*NUM_SLOTS-1:0] sel_flat,
  input logic [NUM_SLOTS-1:0]   force_vec,
  input logic [NUM_SLOTS-1:0]   set_vec,
  input logic [NUM_SLOTS-1:0]   clr_vec,
  input logic [NUM_SLOTS-1:0]   ovf_clr_i,
  input logic [NUM_SLOTS-1:0]   pend_o,
  input logic [NUM_SLOTS-1:0]   ovf_o
);
  localparam int FIELDS_PER_REG = DATA_W / 2;
  localparam int SEL_REGS       = (NUM_SLOTS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
  localparam int FORCE_ADDR     = SEL_REGS;

  // R6
  force_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(FORCE_ADDR)) |-> (reg_rdata_o == '0));

  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      // R6
      force_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && (reg_addr_i == ADDR_W'(FORCE_ADDR)) && reg_wdata_i[k]) |=> pend_o[k]);
      // R5
      bad_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sel_flat[2*k +: 2] == 2'b11) && !force_vec[k]) |-> !set_vec[k]);
      // R7
      start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_vec[k] && !set_vec[k]) |=> !pend_o[k]);
      // R8
      set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_vec[k] && clr_vec[k] && !ovf_clr_i[k]) |=> (pend_o[k] && (ovf_o[k] == $past(ovf_o[k]))));
      // R9
      lost_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_vec[k] && pend_o[k] && !clr_vec[k]) |=> ovf_o[k]);
      // R10
      ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_clr_i[k] && !(set_vec[k] && pend_o[k] && !clr_vec[k])) |=> !ovf_o[k]);
    end
  endgenerate
endmodule

bind conv_req_flags conv_req_flags_chk #(
  .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .sel_flat    (sel_flat),
  .force_vec   (force_vec),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .ovf_clr_i   (ovf_clr_i),
  .pend_o      (pend_o),
  .ovf_o       (ovf_o)
);

// File: tb/conv_req_flags_tb.sv
module conv_req_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] norm = '0;
  logic        irq1 = 1'b0;
  logic        irq2 = 1'b0;
  logic [15:0] start = '0;
  logic [15:0] oclr = '0;
  logic [15:0] pend;
  logic [15:0] ovf;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  conv_req_flags u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .norm_trig_i(norm),
    .irq1_i(irq1), .irq2_i(irq2), .conv_start_i(start), .ovf_clr_i(oclr),
    .pend_o(pend), .ovf_o(ovf)
  );

  // Behavioural reference model.
  int m_sel [16];
  bit m_pend [16];
  bit m_ovf [16];

  initial for (int i = 0; i < 16; i++) begin m_sel[i] = 0; m_pend[i] = 0; m_ovf[i] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_sel[i] = 0; m_pend[i] = 0; m_ovf[i] = 0; end
    end else begin
      for (int i = 0; i < 16; i++) begin
        bit req;
        req = 0;
        if (m_sel[i] == 0)      req = norm[i];
        else if (m_sel[i] == 1) req = irq1;
        else if (m_sel[i] == 2) req = irq2;
        if (wr && addr == 3'd2 && wdata[i]) req = 1;
        if (oclr[i]) m_ovf[i] = 0;
        if (req && m_pend[i] && !start[i]) m_ovf[i] = 1;
        if (req) m_pend[i] = 1;
        else if (start[i]) m_pend[i] = 0;
      end
      if (wr && addr == 3'd0) for (int j = 0; j < 8; j++) m_sel[j] = int'((wdata >> (2*j)) & 16'h3);
      if (wr && addr == 3'd1) for (int j = 0; j < 8; j++) m_sel[8+j] = int'((wdata >> (2*j)) & 16'h3);
    end
  end

  function automatic logic [15:0] pack_bits(input bit v [16]);
    logic [15:0] w = '0;
    for (int i = 0; i < 16; i++) w[i] = v[i];
    return w;
  endfunction

  function automatic logic [15:0] exp_rdata();
    logic [15:0] w = '0;
    case (addr)
      3'd0: for (int j = 0; j < 8; j++) w = w | (16'(m_sel[j]) << (2*j));
      3'd1: for (int j = 0; j < 8; j++) w = w | (16'(m_sel[8+j]) << (2*j));
      3'd3: w = pack_bits(m_pend);
      3'd4: w = pack_bits(m_ovf);
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
    end
  endtask

  // Compare one ns before each rising edge.
  always begin
    @(negedge clk);
    #3;
    check("pend_o", pend, pack_bits(m_pend));
    check("ovf_o", ovf, pack_bits(m_ovf));
    check("reg_rdata_o", rdata, exp_rdata());
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    wr = 0; norm = '0; irq1 = 0; irq2 = 0; start = '0; oclr = '0;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    step(); wr = 1; addr = a; wdata = d;
    step(); wr = 0;
  endtask

  task automatic drain();
    step(); idle(); start = 16'hFFFF; oclr = 16'hFFFF;
    step(); idle();
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state, every address read
    phase = "R1";
    for (int a = 0; a < 8; a++) begin step(); addr = 3'(a); end
    step(); rst_n = 1;
    for (int a = 0; a < 8; a++) begin step(); addr = 3'(a); end

    // R2: select field packing and read-back
    phase = "R2";
    reg_write(3'd0, 16'h1B4E);
    reg_write(3'd1, 16'hC027);
    step(); addr = 3'd0; step(); addr = 3'd1; step(2);
    reg_write(3'd0, 16'h0000);
    reg_write(3'd1, 16'h0000);

    // R3: normal trigger, interrupts ignored
    phase = "R3";
    step(); irq1 = 1; irq2 = 1; addr = 3'd3;
    step(); idle();
    step(); norm = 16'hA5C3;
    step(); idle(); addr = 3'd3;
    drain();

    // R4: interrupt lines select
    phase = "R4";
    reg_write(3'd0, 16'h5555);
    reg_write(3'd1, 16'hAAAA);
    step(); norm = 16'hFFFF;
    step(); idle(); irq1 = 1;
    step(); idle(); addr = 3'd3;
    drain();
    step(); irq2 = 1;
    step(); idle();
    drain();
    reg_write(3'd0, 16'h9966);
    step(); irq2 = 1; norm = 16'h00FF;
    step(); idle();
    drain();

    // R5: invalid select sets nothing
    phase = "R5";
    reg_write(3'd0, 16'hFFFF);
    reg_write(3'd1, 16'hFFFF);
    step(); norm = 16'hFFFF; irq1 = 1; irq2 = 1;
    step(2); idle(); addr = 3'd3;
    step(2);

    // R6: force pulses, read-back zero
    phase = "R6";
    step(); wr = 1; addr = 3'd2; wdata = 16'h8001;
    step(); wr = 0;
    step(); wr = 1; wdata = 16'h0240;
    step(); wr = 0; addr = 3'd2;
    step(); addr = 3'd3;
    step();

    // R7: conversion start clears
    phase = "R7";
    step(); start = 16'h8040;
    step(); idle(); start = 16'h0001;
    step(); idle();
    drain();

    // R8: set and clear collide, overflow untouched
    phase = "R8";
    reg_write(3'd0, 16'h0000);
    reg_write(3'd1, 16'h0000);
    step(); norm = 16'h00F0;
    step(); norm = 16'h0030;
    step(); idle(); addr = 3'd4;
    step(); norm = 16'h00FF; start = 16'h00FF;
    step(); idle(); addr = 3'd3;
    step(); addr = 3'd4;

    // R9: lost request marks overflow
    phase = "R9";
    step(); norm = 16'h0F0F;
    step(); idle();
    step(); norm = 16'h0F00; start = 16'h0100;
    step(); idle(); addr = 3'd4;
    step();

    // R10: overflow clear, lost event wins
    phase = "R10";
    step(); oclr = 16'h000F;
    step(); idle();
    step(); oclr = 16'h0F00; norm = 16'h0300;
    step(); idle();
    drain();

    // R11: status reads and unused addresses
    phase = "R11";
    step(); norm = 16'h1234;
    step(); norm = 16'h0204; addr = 3'd3;
    step(); idle(); addr = 3'd4;
    for (int a = 5; a < 8; a++) begin step(); addr = 3'(a); end
    drain();

    // Mixed traffic across R3 R4 R5 R7 R8 R9 R10
    phase = "R3/R4/R5/R7/R8/R9/R10 mixed";
    for (int n = 0; n < 3000; n++) begin
      step();
      norm  = 16'($urandom) & 16'($urandom);
      irq1  = ($urandom % 4) == 0;
      irq2  = ($urandom % 4) == 0;
      start = 16'($urandom) & 16'($urandom);
      oclr  = 16'($urandom) & 16'($urandom) & 16'($urandom);
      addr  = 3'($urandom);
      wr    = ($urandom % 8) == 0;
      wdata = 16'($urandom);
    end
    step(); idle();
    step(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule